// File: doc/BRIEF.md
# Configuration-Aware Test Access Port

This block is the test access port of a programmable device that also takes its configuration bitstream over the same four-wire serial test interface. It contains the sixteen-state TAP controller, a 10-bit instruction register, and three data paths: a one-bit pass-through, a 32-bit identification word and an 8-bit pin sample register. Next to these it keeps a small model of the configuration sequence. That sequence runs through idle, bitstream loading, a fixed post-load initialization count, and done. A halted state is entered when test logic takes over the I/O buffers.

Which instruction is honoured depends on that sequence. While configuration is idle, loading or initializing, only the pass-through, identification, pin sample, bitstream load, I/O takeover and restart instructions act as themselves. Any other opcode behaves as the pass-through. Once the I/O takeover instruction has halted configuration, or once configuration has finished, every instruction is honoured. Leaving the halted state takes either the restart instruction or a low level on the external reconfigure input. Either one sends configuration back to idle.

Top module: `cfg_tap_top`

## Requirements
- R1: The controller follows the standard sixteen-state TAP graph on TMS at each rising TCK edge. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state. Test-Logic-Reset selects the identification path.
- R2: The pass-through path is one bit long. It captures 0 in Capture-DR, so each TDI bit shifted in appears on TDO one TCK cycle later.
- R3: The identification path captures the ID_VALUE parameter with bit 0 forced to 1 and shifts it out least significant bit first. Bits shifted in follow it after 32 cycles.
- R4: The pin sample instruction (opcode 0x005) captures pin_in in Capture-DR and shifts it out least significant bit first over an 8-bit path.
- R5: Capture-IR loads the value 1 (bit 0 high, bits 9..1 low), which shifts out least significant bit first during Shift-IR.
- R6: While configuration is idle, loading or initializing, the pass-through (0x3FF), identification (0x006) and pin sample instructions work normally and leave bitstream progress unchanged.
- R7: The external-test opcode 0x00F selects the 8-bit pin register only when configuration is halted or done. In idle, load or init states it, like any unknown opcode, selects the one-bit pass-through.
- R8: Completing Update-IR with opcode 0x00D aborts configuration from any state. From the next cycle io_jtag is 1 and conf_done is 0.
- R9: io_jtag returns to 0 only through Update-IR with opcode 0x002 or through reconfig_n sampled low. Both return configuration to idle, with conf_done 0.
- R10: A bitstream bit is counted only at a Shift-DR edge while load opcode 0x003 is active and configuration is idle or loading. After the BITS-th bit, conf_done rises exactly INIT_CYCLES rising TCK edges later. Bits shifted while halted or done are ignored.
- R11: chip_clr_n and chip_oe never change the TAP state, the instruction, the data paths or configuration progress. They only gate user_rst_n (chip_clr_n AND conf_done) and user_io_oe (chip_oe AND conf_done AND NOT io_jtag).
- R12: TDO and tdo_en change only on the falling TCK edge. tdo_en is 1 exactly while the controller is in Shift-IR or Shift-DR.
- R13: Test-Logic-Reset does not clear the configuration state, the bit count, conf_done or io_jtag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released on TCK |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable (1 in Shift-IR/Shift-DR) |
| reconfig_n | input | 1 | Active-low configuration restart |
| chip_clr_n | input | 1 | Device-wide active-low clear for user logic |
| chip_oe | input | 1 | Device-wide output enable for user I/O |
| pin_in | input | BSR_W | Pin levels seen by the sample register |
| conf_done | output | 1 | Configuration finished |
| io_jtag | output | 1 | I/O buffers held by test logic |
| user_io_oe | output | 1 | Output enable granted to user I/O |
| user_rst_n | output | 1 | Active-low reset for user logic |

## Verification
The assertions assume that TMS, TDI and reconfig_n are stable around each rising TCK edge. They also assume that trst_n is released only once the reset synchronizer has settled. The checks on io_jtag assume that the restart input and the takeover instruction are not used in the same cycle. The stimulus changes all inputs half a period after the rising edge, never drives reconfig_n low during an Update-IR cycle, and walks the TAP only through legal TMS paths from Run-Test/Idle.

// File: rtl/cfg_tap_pkg.sv
package cfg_tap_pkg;

  typedef enum logic [3:0] {
    TS_TLR    = 4'h0,
    TS_RTI    = 4'h1,
    TS_SEL_DR = 4'h2,
    TS_CAP_DR = 4'h3,
    TS_SHF_DR = 4'h4,
    TS_EX1_DR = 4'h5,
    TS_PAU_DR = 4'h6,
    TS_EX2_DR = 4'h7,
    TS_UPD_DR = 4'h8,
    TS_SEL_IR = 4'h9,
    TS_CAP_IR = 4'hA,
    TS_SHF_IR = 4'hB,
    TS_EX1_IR = 4'hC,
    TS_PAU_IR = 4'hD,
    TS_EX2_IR = 4'hE,
    TS_UPD_IR = 4'hF
  } tap_st_t;

  typedef enum logic [2:0] {
    CF_IDLE = 3'd0,
    CF_LOAD = 3'd1,
    CF_INIT = 3'd2,
    CF_DONE = 3'd3,
    CF_HALT = 3'd4
  } cfg_st_t;

  typedef enum logic [2:0] {
    DS_BYP  = 3'd0,
    DS_ID   = 3'd1,
    DS_SMP  = 3'd2,
    DS_EXT  = 3'd3,
    DS_LOAD = 3'd4
  } dr_sel_t;

endpackage

// File: rtl/cfg_tap_fsm.sv
module cfg_tap_fsm
  import cfg_tap_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_t state
);

  tap_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      TS_TLR:    st_d = tms ? TS_TLR    : TS_RTI;
      TS_RTI:    st_d = tms ? TS_SEL_DR : TS_RTI;
      TS_SEL_DR: st_d = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: st_d = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: st_d = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: st_d = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: st_d = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: st_d = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: st_d = tms ? TS_SEL_DR : TS_RTI;
      TS_SEL_IR: st_d = tms ? TS_TLR    : TS_CAP_IR;
      TS_CAP_IR: st_d = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: st_d = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: st_d = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: st_d = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: st_d = tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: st_d = tms ? TS_SEL_DR : TS_RTI;
      default:   st_d = TS_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st_q <= TS_TLR;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/cfg_tap_ir.sv
module cfg_tap_ir
  import cfg_tap_pkg::*;
#(
  parameter int             IR_W      = 10,
  parameter logic [IR_W-1:0] OP_BYPASS = '1,
  parameter logic [IR_W-1:0] OP_IDCODE = 10'h006,
  parameter logic [IR_W-1:0] OP_SAMPLE = 10'h005,
  parameter logic [IR_W-1:0] OP_EXTEST = 10'h00F,
  parameter logic [IR_W-1:0] OP_CFGIO  = 10'h00D,
  parameter logic [IR_W-1:0] OP_PULSE  = 10'h002,
  parameter logic [IR_W-1:0] OP_LOAD   = 10'h003
) (
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tdi,
  input  tap_st_t state,
  input  cfg_st_t cfg_st,
  output logic    ir_lsb,
  output dr_sel_t dr_sel,
  output logic    cfgio_hit,
  output logic    restart_hit
);

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] ir_q, ir_d;
  dr_sel_t         sel_q, sel_d, decoded;
  logic            restricted;
  logic            ir_en, sel_en;

  // configuration running (or not yet started): only the safe set passes
  assign restricted = (cfg_st == CF_IDLE) || (cfg_st == CF_LOAD) ||
                      (cfg_st == CF_INIT);

  always_comb begin
    if (ir_q == OP_BYPASS)      decoded = DS_BYP;
    else if (ir_q == OP_IDCODE) decoded = DS_ID;
    else if (ir_q == OP_SAMPLE) decoded = DS_SMP;
    else if (ir_q == OP_LOAD)   decoded = DS_LOAD;
    else if (ir_q == OP_EXTEST) decoded = restricted ? DS_BYP : DS_EXT;
    else                        decoded = DS_BYP;
  end

  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir_q;
    if (state == TS_CAP_IR) begin
      ir_en = 1'b1;
      ir_d  = IR_CAPTURE;
    end else if (state == TS_SHF_IR) begin
      ir_en = 1'b1;
      ir_d  = {tdi, ir_q[IR_W-1:1]};
    end
  end

  always_comb begin
    sel_en = 1'b0;
    sel_d  = sel_q;
    if (state == TS_TLR) begin
      sel_en = 1'b1;
      sel_d  = DS_ID;
    end else if (state == TS_UPD_IR) begin
      sel_en = 1'b1;
      sel_d  = decoded;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_q <= IR_CAPTURE;
    else if (ir_en) ir_q <= ir_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sel_q <= DS_ID;
    else if (sel_en) sel_q <= sel_d;
  end

  assign ir_lsb      = ir_q[0];
  assign dr_sel      = sel_q;
  assign cfgio_hit   = (state == TS_UPD_IR) && (ir_q == OP_CFGIO);
  assign restart_hit = (state == TS_UPD_IR) && (ir_q == OP_PULSE);

endmodule

// File: rtl/cfg_tap_dr.sv
module cfg_tap_dr
  import cfg_tap_pkg::*;
#(
  parameter int          BSR_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A2B_C0DD
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tdi,
  input  tap_st_t          state,
  input  dr_sel_t          dr_sel,
  input  logic [BSR_W-1:0] pin_in,
  input  logic             ir_lsb,
  output logic             tdo,
  output logic             tdo_en
);

  localparam int          ID_W     = 32;
  localparam logic [31:0] ID_FIXED = {ID_VALUE[ID_W-1:1], 1'b1};

  logic             byp_q, byp_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [BSR_W-1:0] bsr_q, bsr_d;
  logic             dr_en;
  logic             tdo_d, tdo_q, en_q, shifting;

  assign dr_en = (state == TS_CAP_DR) || (state == TS_SHF_DR);

  always_comb begin
    byp_d = byp_q;
    id_d  = id_q;
    bsr_d = bsr_q;
    if (state == TS_CAP_DR) begin
      case (dr_sel)
        DS_ID:          id_d  = ID_FIXED;
        DS_SMP, DS_EXT: bsr_d = pin_in;
        default:        byp_d = 1'b0;
      endcase
    end else if (state == TS_SHF_DR) begin
      case (dr_sel)
        DS_ID:          id_d  = {tdi, id_q[ID_W-1:1]};
        DS_SMP, DS_EXT: bsr_d = {tdi, bsr_q[BSR_W-1:1]};
        default:        byp_d = tdi;
      endcase
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      bsr_q <= '0;
    end else if (dr_en) begin
      byp_q <= byp_d;
      id_q  <= id_d;
      bsr_q <= bsr_d;
    end
  end

  assign shifting = (state == TS_SHF_DR) || (state == TS_SHF_IR);

  always_comb begin
    if (state == TS_SHF_IR) tdo_d = ir_lsb;
    else begin
      case (dr_sel)
        DS_ID:          tdo_d = id_q[0];
        DS_SMP, DS_EXT: tdo_d = bsr_q[0];
        default:        tdo_d = byp_q;
      endcase
    end
  end

  // output stage on the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q <= shifting;
      if (shifting) tdo_q <= tdo_d;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_en = en_q;

endmodule

// File: rtl/cfg_tap_cfg.sv
module cfg_tap_cfg
  import cfg_tap_pkg::*;
#(
  parameter int BITS        = 64,
  parameter int INIT_CYCLES = 1094
) (
  input  logic    tck,
  input  logic    rst_n,
  input  logic    data_bit,
  input  logic    cfgio_hit,
  input  logic    restart_hit,
  input  logic    reconfig_n,
  output cfg_st_t cfg_st,
  output logic    in_init
);

  localparam int BW = $clog2(BITS + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(BITS - 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

  cfg_st_t       st_q, st_d;
  logic [BW-1:0] bc_q, bc_d;
  logic [IW-1:0] ic_q, ic_d;

  always_comb begin
    st_d = st_q;
    bc_d = bc_q;
    ic_d = ic_q;
    if (!reconfig_n || restart_hit) begin
      st_d = CF_IDLE;
      bc_d = '0;
      ic_d = '0;
    end else if (cfgio_hit) begin
      st_d = CF_HALT;
      bc_d = '0;
      ic_d = '0;
    end else begin
      case (st_q)
        CF_IDLE, CF_LOAD: begin
          if (data_bit) begin
            if (bc_q == BIT_LAST) begin
              st_d = CF_INIT;
              bc_d = '0;
            end else begin
              st_d = CF_LOAD;
              bc_d = bc_q + BW'(1);
            end
          end
        end
        CF_INIT: begin
          if (ic_q == INIT_LAST) begin
            st_d = CF_DONE;
            ic_d = '0;
          end else begin
            ic_d = ic_q + IW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CF_IDLE;
      bc_q <= '0;
      ic_q <= '0;
    end else begin
      st_q <= st_d;
      bc_q <= bc_d;
      ic_q <= ic_d;
    end
  end

  assign cfg_st  = st_q;
  assign in_init = (st_q == CF_INIT);

endmodule

// File: rtl/cfg_tap_top.sv
module cfg_tap_top
  import cfg_tap_pkg::*;
#(
  parameter int              IR_W        = 10,
  parameter logic [IR_W-1:0] OP_BYPASS   = '1,
  parameter logic [IR_W-1:0] OP_IDCODE   = 10'h006,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 10'h005,
  parameter logic [IR_W-1:0] OP_EXTEST   = 10'h00F,
  parameter logic [IR_W-1:0] OP_CFGIO    = 10'h00D,
  parameter logic [IR_W-1:0] OP_PULSE    = 10'h002,
  parameter logic [IR_W-1:0] OP_LOAD     = 10'h003,
  parameter logic [31:0]     ID_VALUE    = 32'h1A2B_C0DD,
  parameter int              BSR_W       = 8,
  parameter int              BITS        = 64,
  parameter int              INIT_CYCLES = 1094
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic             reconfig_n,
  input  logic             chip_clr_n,
  input  logic             chip_oe,
  input  logic [BSR_W-1:0] pin_in,
  output logic             conf_done,
  output logic             io_jtag,
  output logic             user_io_oe,
  output logic             user_rst_n
);

  logic [1:0] rsync_q;
  logic       rst_n;
  tap_st_t    tap_st;
  cfg_st_t    cfg_st;
  dr_sel_t    dr_sel;
  logic       ir_lsb, cfgio_hit, restart_hit, in_init, load_bit;

  // asynchronous assertion, release aligned to TCK
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  cfg_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (tap_st)
  );

  cfg_tap_ir #(
    .IR_W      (IR_W),
    .OP_BYPASS (OP_BYPASS),
    .OP_IDCODE (OP_IDCODE),
    .OP_SAMPLE (OP_SAMPLE),
    .OP_EXTEST (OP_EXTEST),
    .OP_CFGIO  (OP_CFGIO),
    .OP_PULSE  (OP_PULSE),
    .OP_LOAD   (OP_LOAD)
  ) u_ir (
    .tck         (tck),
    .rst_n       (rst_n),
    .tdi         (tdi),
    .state       (tap_st),
    .cfg_st      (cfg_st),
    .ir_lsb      (ir_lsb),
    .dr_sel      (dr_sel),
    .cfgio_hit   (cfgio_hit),
    .restart_hit (restart_hit)
  );

  cfg_tap_dr #(
    .BSR_W    (BSR_W),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (tap_st),
    .dr_sel (dr_sel),
    .pin_in (pin_in),
    .ir_lsb (ir_lsb),
    .tdo    (tdo),
    .tdo_en (tdo_en)
  );

  assign load_bit = (tap_st == TS_SHF_DR) && (dr_sel == DS_LOAD);

  cfg_tap_cfg #(
    .BITS        (BITS),
    .INIT_CYCLES (INIT_CYCLES)
  ) u_cfg (
    .tck         (tck),
    .rst_n       (rst_n),
    .data_bit    (load_bit),
    .cfgio_hit   (cfgio_hit),
    .restart_hit (restart_hit),
    .reconfig_n  (reconfig_n),
    .cfg_st      (cfg_st),
    .in_init     (in_init)
  );

  assign conf_done  = (cfg_st == CF_DONE);
  assign io_jtag    = (cfg_st == CF_HALT);
  assign user_io_oe = chip_oe & conf_done & ~io_jtag;
  assign user_rst_n = chip_clr_n & conf_done;

endmodule

// File: rtl/cfg_tap_chk.sv
module cfg_tap_chk
  import cfg_tap_pkg::*;
(
  input logic    tck,
  input logic    rst_n,
  input logic    tms,
  input logic    tdo_en,
  input tap_st_t tap_st,
  input cfg_st_t cfg_st,
  input logic    conf_done,
  input logic    io_jtag,
  input logic    cfgio_hit,
  input logic    restart_hit,
  input logic    reconfig_n,
  input logic    in_init
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)             hi_cnt <= 3'd0;
    else if (!tms)          hi_cnt <= 3'd0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  // R1
  tlr_after_five_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_cnt == 3'd5) |-> (tap_st == TS_TLR));

  // R12
  tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == ((tap_st == TS_SHF_DR) || (tap_st == TS_SHF_IR)));

  // R8
  cfgio_takeover_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (cfgio_hit && reconfig_n) |=> (io_jtag && !conf_done));

  // R9
  halt_exit_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $fell(io_jtag) |-> $past(restart_hit || !reconfig_n));

  // R10
  done_after_init_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(conf_done) |-> $past(in_init));

  // R6
  legal_keeps_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (cfg_st == CF_LOAD && tap_st == TS_UPD_IR && reconfig_n &&
     !cfgio_hit && !restart_hit) |=> (cfg_st == CF_LOAD));

  // R13
  tlr_keeps_done_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (tap_st == TS_TLR && conf_done && reconfig_n) |=> conf_done);

endmodule

bind cfg_tap_top cfg_tap_chk u_chk (
  .tck         (tck),
  .rst_n       (rst_n),
  .tms         (tms),
  .tdo_en      (tdo_en),
  .tap_st      (tap_st),
  .cfg_st      (cfg_st),
  .conf_done   (conf_done),
  .io_jtag     (io_jtag),
  .cfgio_hit   (cfgio_hit),
  .restart_hit (restart_hit),
  .reconfig_n  (reconfig_n),
  .in_init     (in_init)
);

// File: tb/tb_cfg_tap_top.sv
module tb_cfg_tap_top;

  localparam int          IR_W        = 10;
  localparam logic [9:0]  OP_BYPASS   = 10'h3FF;
  localparam logic [9:0]  OP_IDCODE   = 10'h006;
  localparam logic [9:0]  OP_SAMPLE   = 10'h005;
  localparam logic [9:0]  OP_EXTEST   = 10'h00F;
  localparam logic [9:0]  OP_CFGIO    = 10'h00D;
  localparam logic [9:0]  OP_PULSE    = 10'h002;
  localparam logic [9:0]  OP_LOAD     = 10'h003;
  localparam logic [31:0] ID_VALUE    = 32'h1A2B_C0DD;
  localparam int          BSR_W       = 8;
  localparam int          BITS        = 64;
  localparam int          INIT_CYCLES = 1094;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic trst_n, tms, tdi, reconfig_n, chip_clr_n, chip_oe;
  logic [BSR_W-1:0] pin_in;
  logic tdo, tdo_en, conf_done, io_jtag, user_io_oe, user_rst_n;

  cfg_tap_top dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_en(tdo_en), .reconfig_n(reconfig_n), .chip_clr_n(chip_clr_n),
    .chip_oe(chip_oe), .pin_in(pin_in), .conf_done(conf_done),
    .io_jtag(io_jtag), .user_io_oe(user_io_oe), .user_rst_n(user_rst_n)
  );

  typedef struct {
    logic  v;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;
  logic mon_v;

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one expected bit per shift edge
  always @(posedge tck) begin
    if (tdo_en === 1'b1) begin
      mon_v = tdo;
      #2;
      chk(tdo === mon_v, "R12 tdo moved near rising edge", tdo, mon_v);
      if (q.size() == 0) chk(1'b0, "R12 unexpected shift", mon_v, 0);
      else begin
        e = q.pop_front();
        chk(mon_v === e.v, e.tag, mon_v, e.v);
      end
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m;
    tdi = d;
  endtask

  task automatic settle();
    @(negedge tck); #2;
  endtask

  task automatic tap_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [9:0] op);
    exp_t x;
    for (int i = 0; i < IR_W; i++) begin
      x.v = (i == 0);
      x.tag = "R5 capture-IR";
      q.push_back(x);
    end
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < IR_W; i++) step(i == IR_W - 1, op[i]);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic scan_dr(input int len, input int plen, input logic [127:0] cap,
                         input logic [127:0] data, input string tag);
    exp_t x;
    for (int i = 0; i < len; i++) begin
      x.v = (i < plen) ? cap[i] : data[i - plen];
      x.tag = tag;
      q.push_back(x);
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < len; i++) step(i == len - 1, data[i]);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  localparam logic [63:0] STREAM = 64'hF0E1_D2C3_B4A5_9687;

  task automatic finish_init_exact(input string tag);
    for (int i = 0; i < INIT_CYCLES - 3; i++) step(1'b0, 1'b0);
    settle();
    chk(conf_done === 1'b0, {tag, " done one edge early"}, conf_done, 0);
    settle();
    chk(conf_done === 1'b1, {tag, " done on count"}, conf_done, 1);
  endtask

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; reconfig_n = 1'b1;
    chip_clr_n = 1'b1; chip_oe = 1'b1; pin_in = 8'hA5;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    repeat (3) @(negedge tck);
    #2;
    // reset state
    chk(conf_done === 1'b0, "R10 reset done", conf_done, 0);
    chk(io_jtag === 1'b0, "R9 reset io_jtag", io_jtag, 0);
    chk(tdo_en === 1'b0, "R12 reset tdo_en", tdo_en, 0);

    // R1 R3: Test-Logic-Reset selects the identification path
    tap_reset();
    scan_dr(40, 32, {96'd0, ID_VALUE | 32'd1}, 128'h5C, "R3 idcode");
    // R2
    load_ir(OP_BYPASS);
    scan_dr(16, 1, 128'd0, 128'hB36D, "R2 bypass");
    // R4
    load_ir(OP_SAMPLE);
    scan_dr(16, 8, {120'd0, pin_in}, 128'h3C, "R4 sample");
    // R7: restricted while idle
    load_ir(OP_EXTEST);
    scan_dr(12, 1, 128'd0, 128'hA5A, "R7 extest as bypass");

    // R10 first part of bitstream
    load_ir(OP_LOAD);
    scan_dr(20, 1, 128'd0, {64'd0, STREAM}, "R10 stream part 1");
    // R6: safe instructions during load
    load_ir(OP_IDCODE);
    scan_dr(32, 32, {96'd0, ID_VALUE | 32'd1}, 128'd0, "R6 idcode in load");
    pin_in = 8'h3C;
    load_ir(OP_SAMPLE);
    scan_dr(8, 8, {120'd0, 8'h3C}, 128'd0, "R6 sample in load");
    load_ir(OP_EXTEST);
    scan_dr(6, 1, 128'd0, 128'h15, "R7 extest in load");
    // R11: device-wide pins do nothing to the test logic
    chip_clr_n = 1'b0; chip_oe = 1'b0;
    load_ir(OP_BYPASS);
    scan_dr(8, 1, 128'd0, 128'h96, "R11 bypass with clear low");
    chip_clr_n = 1'b1; chip_oe = 1'b1;
    // R13: Test-Logic-Reset keeps the bit count
    tap_reset();
    load_ir(OP_LOAD);
    scan_dr(44, 1, 128'd0, {64'd0, STREAM} >> 20, "R10 stream part 2");
    finish_init_exact("R10 R6 R11 R13");
    chk(io_jtag === 1'b0, "R8 io_jtag after done", io_jtag, 0);
    chk(user_io_oe === 1'b1, "R11 user_io_oe", user_io_oe, 1);
    chk(user_rst_n === 1'b1, "R11 user_rst_n", user_rst_n, 1);
    chip_oe = 1'b0; chip_clr_n = 1'b0;
    settle();
    chk(user_io_oe === 1'b0, "R11 chip_oe gate", user_io_oe, 0);
    chk(user_rst_n === 1'b0, "R11 chip_clr_n gate", user_rst_n, 0);
    chk(conf_done === 1'b1, "R11 done unaffected", conf_done, 1);
    chip_oe = 1'b1; chip_clr_n = 1'b1;
    tap_reset();
    settle();
    chk(conf_done === 1'b1, "R13 done after TLR", conf_done, 1);

    // R7: honoured once done
    load_ir(OP_EXTEST);
    scan_dr(12, 8, {120'd0, pin_in}, 128'h9, "R7 extest when done");

    // R8
    load_ir(OP_CFGIO);
    settle();
    chk(io_jtag === 1'b1, "R8 io_jtag", io_jtag, 1);
    chk(conf_done === 1'b0, "R8 done cleared", conf_done, 0);
    chk(user_io_oe === 1'b0, "R11 oe under test", user_io_oe, 0);
    load_ir(OP_EXTEST);
    scan_dr(10, 8, {120'd0, pin_in}, 128'h3, "R7 extest when halted");
    // R10: load ignored while halted
    load_ir(OP_LOAD);
    scan_dr(BITS, 1, 128'd0, {64'd0, STREAM}, "R10 stream while halted");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0);
    settle();
    chk(conf_done === 1'b0, "R10 ignored when halted", conf_done, 0);
    // R9 R13: TLR and device pins do not leave halt
    tap_reset();
    chip_clr_n = 1'b0;
    settle();
    chk(io_jtag === 1'b1, "R9 halt held", io_jtag, 1);
    chip_clr_n = 1'b1;

    // R9 restart instruction
    load_ir(OP_PULSE);
    settle();
    chk(io_jtag === 1'b0, "R9 restart instruction", io_jtag, 0);
    chk(conf_done === 1'b0, "R9 idle after restart", conf_done, 0);
    load_ir(OP_EXTEST);
    scan_dr(6, 1, 128'd0, 128'h2D, "R7 extest after restart");

    // R9 restart pin
    load_ir(OP_CFGIO);
    settle();
    chk(io_jtag === 1'b1, "R8 second takeover", io_jtag, 1);
    @(negedge tck); #1; reconfig_n = 1'b0;
    @(negedge tck); #1; reconfig_n = 1'b1;
    settle();
    chk(io_jtag === 1'b0, "R9 restart pin", io_jtag, 0);
    load_ir(OP_LOAD);
    scan_dr(BITS, 1, 128'd0, {64'd0, ~STREAM}, "R10 full stream");
    finish_init_exact("R10 R9 reload");

    settle();
    chk(q.size() == 0, "R12 leftover expected bits", q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge tck);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule